// File: doc/BRIEF.md
# Program Memory Long-Write Controller

This block sits between a processor core's table-write port and an on-chip program memory. Each table write carries one byte and a byte address. The block keeps the two bytes of a 16-bit word in a pair of holding latches. The low byte sits at the even address and the high byte at the odd address. Most writes only refresh a latch. These are short writes, and they never touch the memory.

A long write needs three things at once: a write to the odd byte, a sticky long-write enable, and the programming voltage. When it starts, the block halts the core and holds a programming strobe toward the memory. The strobe carries the word address and the latched word. There is no timer, so the phase lasts until one of two things ends it. An interrupt request ends it cleanly, with a one-cycle done pulse. A reset aborts it without that pulse.

Software can set the long-write enable but has no way to clear it. Only the power-on reset or the external reset clears it. If the programming voltage drops while the phase is running, the phase carries on and a sticky fault flag is raised.

Top module: `pmw_longwrite_ctrl`

## Requirements
- R1: A table write to an even byte address (address bit 0 = 0) loads the low-byte latch and never starts a programming phase.
- R2: An idle table write to an odd byte address starts a phase on the next clock edge when both of these hold: `lwe_o` is 1 and `vpp_ok` is 1. The phase raises `halt_o` and `prog_active_o`, with `prog_waddr_o` equal to the byte address shifted right by one and `prog_wdata_o` equal to {odd byte, even latch}.
- R3: If the long-write enable is clear or `vpp_ok` is low, a write of either parity is a short write. It updates a latch only and starts no phase.
- R4: `lwe_set` sets the long-write enable, and `lwe_o` shows its value. The enable stays set across any number of phases and can be cleared only by `rst_n` or `ext_rst_n`.
- R5: For the whole phase, `halt_o` and `prog_active_o` stay high and the word address and data stay stable. There is no timeout.
- R6: When `irq_term` is high during a phase, the next edge lowers `halt_o` and `prog_active_o` and gives a `done_o` pulse exactly one cycle long. While idle, `irq_term` has no effect.
- R7: Either reset, applied at a clock edge, ends any phase at once without a `done_o` pulse and clears the enable and the fault flag.
- R8: Table writes made during a phase are ignored. They change neither the word driven to memory nor the holding latches.
- R9: If `vpp_ok` is low at an edge during a phase, the phase continues and `vfault_o` becomes 1. The flag stays set until the next phase starts or a reset occurs.
- R10: Reset clears both holding latches to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n | input | 1 | External reset, synchronous, active low |
| tw_valid | input | 1 | Table-write strobe, one byte per cycle |
| tw_addr | input | ADDR_W | Byte address of the table write |
| tw_data | input | BYTE_W | Byte written |
| lwe_set | input | 1 | Request to set the sticky long-write enable |
| vpp_ok | input | 1 | Programming voltage present |
| irq_term | input | 1 | Interrupt request that ends a phase |
| lwe_o | output | 1 | Current value of the sticky long-write enable |
| halt_o | output | 1 | Core halt, high during a phase |
| prog_active_o | output | 1 | Programming strobe toward memory |
| prog_waddr_o | output | ADDR_W-1 | Word address being programmed |
| prog_wdata_o | output | 2*BYTE_W | Word being programmed |
| done_o | output | 1 | One-cycle pulse when an interrupt ends a phase |
| vfault_o | output | 1 | Sticky flag: voltage lost during a phase |

## Verification
The hardest state to reach from the ports is a phase that has already had a voltage dropout and has also received ignored writes. Only the next phase shows whether those writes leaked into the latches. The stimulus opens a long write and holds it for many cycles. During that time it pulses `vpp_ok` low and issues writes of both parities. It then ends the phase with an interrupt and starts a second long write from a single odd write. The low byte of that second word shows whether the even latch kept its value from before the first phase. A reset in the middle of the second phase, followed by an odd write, shows that the enable was cleared and that no done pulse was given.

// File: rtl/pmw_pkg.sv
// Package pmw_pkg
// Shared types for the program memory long-write controller.
// Assumes: one phase state machine with two states.
package pmw_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } pmw_phase_e;
endpackage

// File: rtl/pmw_lwe_reg.sv
// Module pmw_lwe_reg
// Holds the sticky long-write enable. A request can set it.
// Nothing but reset clears it.
// Assumes: rst_all_n is already the AND of every reset source.
module pmw_lwe_reg (
    input  logic clk,
    input  logic rst_all_n,
    input  logic set_req,
    output logic lwe_q
);
    // Set on request; clear only on reset.
    always_ff @(posedge clk) begin
        if (!rst_all_n)   lwe_q <= 1'b0;
        else if (set_req) lwe_q <= 1'b1;
    end
endmodule

// File: rtl/pmw_latch.sv
// Module pmw_latch
// Two byte-wide holding latches, one per byte lane, plus the word
// address captured when a phase starts.
// Assumes: wr_en is already gated off while a phase is active.
module pmw_latch #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_all_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  capture,
    output logic [2*BYTE_W-1:0]   word,
    output logic [ADDR_W-2:0]     waddr
);
    localparam int LANES = 2;

    logic [BYTE_W-1:0] lane_val [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] q;
        // Load this lane when an accepted write selects it.
        always_ff @(posedge clk) begin
            if (!rst_all_n)
                q <= '0;
            else if (wr_en && (wr_addr[0] == (g != 0)))
                q <= wr_data;
        end
        assign lane_val[g] = q;
    end

    assign word = {lane_val[1], lane_val[0]};

    // Capture the word address of the odd write that opens a phase.
    always_ff @(posedge clk) begin
        if (!rst_all_n)   waddr <= '0;
        else if (capture) waddr <= wr_addr[ADDR_W-1:1];
    end
endmodule

// File: rtl/pmw_phase_fsm.sv
// Module pmw_phase_fsm
// Programming phase sequencer. It enters the phase on start and leaves on
// an interrupt, with a one-cycle done pulse. Reset aborts it silently.
// It also keeps the sticky voltage-fault flag.
// Assumes: start is only raised while idle.
module pmw_phase_fsm
    import pmw_pkg::*;
(
    input  logic clk,
    input  logic rst_all_n,
    input  logic start,
    input  logic irq_term,
    input  logic vpp_ok,
    output logic active,
    output logic done,
    output logic vfault
);
    pmw_phase_e state_q, state_d;

    // Next-state selection for the phase.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PH_IDLE: if (start)    state_d = PH_PROG;
            PH_PROG: if (irq_term) state_d = PH_IDLE;
            default:               state_d = PH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_all_n) state_q <= PH_IDLE;
        else            state_q <= state_d;
    end

    // One-cycle done pulse when an interrupt closes the phase.
    always_ff @(posedge clk) begin
        if (!rst_all_n) done <= 1'b0;
        else            done <= (state_q == PH_PROG) && irq_term;
    end

    // Sticky fault flag: set on voltage loss, cleared when a phase opens.
    always_ff @(posedge clk) begin
        if (!rst_all_n)
            vfault <= 1'b0;
        else if (start)
            vfault <= 1'b0;
        else if ((state_q == PH_PROG) && !vpp_ok)
            vfault <= 1'b1;
    end

    assign active = (state_q == PH_PROG);
endmodule

// File: rtl/pmw_longwrite_ctrl.sv
// Module pmw_longwrite_ctrl (top)
// Gathers table-write bytes into holding latches. It opens a long
// programming phase when an odd-byte write meets both the sticky enable
// and the programming voltage, and halts the core until an interrupt
// or a reset.
// Assumes: both resets are synchronous to clk and active low.
module pmw_longwrite_ctrl #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_rst_n,
    input  logic                  tw_valid,
    input  logic [ADDR_W-1:0]     tw_addr,
    input  logic [BYTE_W-1:0]     tw_data,
    input  logic                  lwe_set,
    input  logic                  vpp_ok,
    input  logic                  irq_term,
    output logic                  lwe_o,
    output logic                  halt_o,
    output logic                  prog_active_o,
    output logic [ADDR_W-2:0]     prog_waddr_o,
    output logic [2*BYTE_W-1:0]   prog_wdata_o,
    output logic                  done_o,
    output logic                  vfault_o
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              rst_all_n;
    logic              lwe_q;
    logic              active;
    logic              accept;
    logic              start;
    logic [WORD_W-1:0] word;

    assign rst_all_n = rst_n & ext_rst_n;
    assign accept    = tw_valid & ~active;
    assign start     = accept & tw_addr[0] & lwe_q & vpp_ok;

    pmw_lwe_reg u_lwe (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .set_req   (lwe_set),
        .lwe_q     (lwe_q)
    );

    pmw_latch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_latch (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .wr_en     (accept),
        .wr_addr   (tw_addr),
        .wr_data   (tw_data),
        .capture   (start),
        .word      (word),
        .waddr     (prog_waddr_o)
    );

    pmw_phase_fsm u_fsm (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .start     (start),
        .irq_term  (irq_term),
        .vpp_ok    (vpp_ok),
        .active    (active),
        .done      (done_o),
        .vfault    (vfault_o)
    );

    assign lwe_o         = lwe_q;
    assign halt_o        = active;
    assign prog_active_o = active;
    assign prog_wdata_o  = word;
endmodule

// File: rtl/pmw_chk.sv
// Module pmw_chk
// Property checker for pmw_longwrite_ctrl, attached with bind.
// Assumes: it sees the top-level ports.
module pmw_chk #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ext_rst_n,
    input logic                tw_valid,
    input logic [ADDR_W-1:0]   tw_addr,
    input logic                vpp_ok,
    input logic                irq_term,
    input logic                lwe_o,
    input logic                halt_o,
    input logic                prog_active_o,
    input logic [ADDR_W-2:0]   prog_waddr_o,
    input logic [2*BYTE_W-1:0] prog_wdata_o,
    input logic                done_o,
    input logic                vfault_o
);
    logic rall_n;
    assign rall_n = rst_n & ext_rst_n;

    // R1
    even_noprog_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (!prog_active_o && tw_valid && !tw_addr[0]) |=> !prog_active_o);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (!prog_active_o && tw_valid && tw_addr[0] && lwe_o && vpp_ok)
        |=> (prog_active_o && halt_o && prog_waddr_o == $past(tw_addr[ADDR_W-1:1])));
    // R3
    short_write_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (!prog_active_o && (!lwe_o || !vpp_ok)) |=> !prog_active_o);
    // R4
    lwe_sticky_chk: assert property (@(posedge clk) disable iff (!rall_n)
        lwe_o |=> lwe_o);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (prog_active_o && !irq_term)
        |=> (prog_active_o && halt_o && $stable(prog_wdata_o) && $stable(prog_waddr_o)));
    // R6
    irq_end_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (prog_active_o && irq_term) |=> (done_o && !prog_active_o && !halt_o));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rall_n)
        done_o |=> !done_o);
    // R7
    reset_abort_chk: assert property (@(posedge clk)
        !rall_n |=> (!prog_active_o && !done_o && !lwe_o && !vfault_o));
    // R9
    vfault_set_chk: assert property (@(posedge clk) disable iff (!rall_n)
        (prog_active_o && !vpp_ok && !irq_term) |=> (vfault_o && prog_active_o));
endmodule

bind pmw_longwrite_ctrl pmw_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_rst_n     (ext_rst_n),
    .tw_valid      (tw_valid),
    .tw_addr       (tw_addr),
    .vpp_ok        (vpp_ok),
    .irq_term      (irq_term),
    .lwe_o         (lwe_o),
    .halt_o        (halt_o),
    .prog_active_o (prog_active_o),
    .prog_waddr_o  (prog_waddr_o),
    .prog_wdata_o  (prog_wdata_o),
    .done_o        (done_o),
    .vfault_o      (vfault_o)
);

// File: tb/pmw_longwrite_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for pmw_longwrite_ctrl.
module pmw_longwrite_ctrl_tb_top;
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ext_rst_n = 1'b1;
    logic                tw_valid = 1'b0;
    logic [ADDR_W-1:0]   tw_addr = '0;
    logic [BYTE_W-1:0]   tw_data = '0;
    logic                lwe_set = 1'b0;
    logic                vpp_ok = 1'b0;
    logic                irq_term = 1'b0;
    logic                lwe_o, halt_o, prog_active_o, done_o, vfault_o;
    logic [ADDR_W-2:0]   prog_waddr_o;
    logic [2*BYTE_W-1:0] prog_wdata_o;

    int checks = 0;
    int errors = 0;
    logic [ADDR_W-2+2*BYTE_W:0] exp_q [$];
    logic prev_active = 1'b0;

    always #4 clk = ~clk;

    pmw_longwrite_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .tw_valid(tw_valid), .tw_addr(tw_addr), .tw_data(tw_data),
        .lwe_set(lwe_set), .vpp_ok(vpp_ok), .irq_term(irq_term),
        .lwe_o(lwe_o), .halt_o(halt_o), .prog_active_o(prog_active_o),
        .prog_waddr_o(prog_waddr_o), .prog_wdata_o(prog_wdata_o),
        .done_o(done_o), .vfault_o(vfault_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: record the phase that should open.
    task automatic expect_phase(input logic [ADDR_W-2:0] wa, input logic [2*BYTE_W-1:0] wd);
        exp_q.push_back({wa, wd});
    endtask

    // One table write, driven between edges.
    task automatic tw(input logic [ADDR_W-1:0] a, input logic [BYTE_W-1:0] d);
        @(negedge clk);
        tw_valid = 1'b1; tw_addr = a; tw_data = d;
        @(negedge clk);
        tw_valid = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_term = 1'b1;
        @(negedge clk); irq_term = 1'b0;
    endtask

    // Monitor: compare every newly opened phase against the scoreboard.
    always @(negedge clk) begin
        if (prog_active_o && !prev_active) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected phase", int'(prog_waddr_o), 0);
            end else begin
                logic [ADDR_W-2+2*BYTE_W:0] e;
                e = exp_q.pop_front();
                check(prog_waddr_o == e[ADDR_W-2+2*BYTE_W:2*BYTE_W], "R2 waddr",
                      int'(prog_waddr_o), int'(e[ADDR_W-2+2*BYTE_W:2*BYTE_W]));
                check(prog_wdata_o == e[2*BYTE_W-1:0], "R2 wdata",
                      int'(prog_wdata_o), int'(e[2*BYTE_W-1:0]));
            end
        end
        prev_active = prog_active_o;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 R10: reset state
        check(!halt_o && !prog_active_o && !done_o && !vfault_o && !lwe_o,
              "R7 reset state", int'(halt_o), 0);
        check(prog_wdata_o == 16'h0000, "R10 latches cleared", int'(prog_wdata_o), 0);

        // R3: enable clear, voltage present
        vpp_ok = 1'b1;
        tw(12'h010, 8'hA5);
        tw(12'h011, 8'h3C);
        check(!prog_active_o, "R3 short write without enable", int'(prog_active_o), 0);
        check(prog_wdata_o == 16'h3CA5, "R3 latches updated", int'(prog_wdata_o), 16'h3CA5);

        // R4: set enable; R3 with voltage absent
        @(negedge clk); lwe_set = 1'b1;
        @(negedge clk); lwe_set = 1'b0;
        check(lwe_o, "R4 enable set", int'(lwe_o), 1);
        vpp_ok = 1'b0;
        tw(12'h011, 8'h3C);
        check(!prog_active_o, "R3 no phase without voltage", int'(prog_active_o), 0);

        // R1: even write never starts
        vpp_ok = 1'b1;
        tw(12'h020, 8'h11);
        check(!prog_active_o && !halt_o, "R1 even write", int'(prog_active_o), 0);

        // R2: long write
        expect_phase(11'h010, 16'h2211);
        tw(12'h021, 8'h22);
        check(halt_o && prog_active_o, "R2 phase open", int'(halt_o), 1);

        // R5: held with no timeout
        begin
            int bad = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (!halt_o || !prog_active_o || prog_wdata_o != 16'h2211) bad++;
            end
            check(bad == 0, "R5 held phase", bad, 0);
        end

        // R8: writes during the phase are ignored
        tw(12'h030, 8'h99);
        tw(12'h031, 8'h77);
        check(prog_wdata_o == 16'h2211 && prog_waddr_o == 11'h010,
              "R8 writes ignored", int'(prog_wdata_o), 16'h2211);

        // R9: voltage dropout mid-phase
        @(negedge clk); vpp_ok = 1'b0;
        @(negedge clk); vpp_ok = 1'b1;
        check(vfault_o && prog_active_o, "R9 fault flagged, phase held", int'(vfault_o), 1);

        // R6: interrupt ends the phase
        pulse_irq();
        check(!prog_active_o && !halt_o && done_o, "R6 irq end", int'(done_o), 1);
        @(negedge clk);
        check(!done_o, "R6 done one cycle", int'(done_o), 0);
        check(vfault_o, "R9 fault sticky after phase", int'(vfault_o), 1);

        // R6: interrupt while idle has no effect
        pulse_irq();
        check(!done_o && !prog_active_o, "R6 idle irq ignored", int'(done_o), 0);

        // R4 R8: second phase without re-setting; low byte from before
        expect_phase(11'h020, 16'h5511);
        tw(12'h041, 8'h55);
        check(prog_active_o, "R4 enable still set", int'(prog_active_o), 1);
        check(!vfault_o, "R9 fault cleared at new phase", int'(vfault_o), 0);

        // R7: external reset aborts without done
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk); ext_rst_n = 1'b1;
        check(!prog_active_o && !halt_o && !done_o, "R7 reset abort", int'(prog_active_o), 0);
        @(negedge clk);
        check(!done_o, "R7 no done after reset", int'(done_o), 0);

        // R4: enable cleared by reset
        tw(12'h041, 8'h66);
        check(!prog_active_o && !lwe_o, "R4 enable cleared by reset", int'(lwe_o), 0);

        // R10: low latch zero after reset
        @(negedge clk); lwe_set = 1'b1;
        @(negedge clk); lwe_set = 1'b0;
        expect_phase(11'h021, 16'h7700);
        tw(12'h043, 8'h77);
        pulse_irq();
        check(done_o, "R6 second done", int'(done_o), 1);

        // R7: power-on reset also aborts
        @(negedge clk); lwe_set = 1'b1;
        @(negedge clk); lwe_set = 1'b0;
        expect_phase(11'h022, 16'h8800);
        tw(12'h045, 8'h88);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(!prog_active_o && !done_o && !lwe_o, "R7 power-on abort", int'(prog_active_o), 0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all phases seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule